// File: doc/BRIEF.md
# Per-Core Cache Set Index Remapper

This block sits in front of the tag and data arrays of a shared set-associative cache. It turns the set index taken from a request address into the set index actually used for the lookup. The transform depends on which core issued the request. Each core therefore spreads its working set over the sets in its own way, which reduces conflicts between cores that would otherwise crowd the same sets.

Every core owns a small configuration word with two fields. The first field enables bitwise inversion of the index. The second field selects an addend that only touches the upper index bits. Because the addend is confined to the top bits, the carry chain is only a few bits long and the transform costs a handful of gate levels.

Each core also keeps the configuration it had before its last update. The block outputs two indices: one mapped with the current configuration, and one mapped with the previous configuration. A lookup can then probe both sets while blocks placed under the old mapping are still resident. The configuration registers are the only state. Both mapped indices are combinational functions of the request and the stored configuration.

Top module: `cache_index_mapper`

## Requirements
- R1: After reset every core's current and previous configuration is inversion off and addend select 0, so both `cur_index` and `prev_index` equal `req_index` for every core.
- R2: With inversion on (`cfg_inv`=1) and addend select 0, the mapped index is the bitwise complement of the raw index over all IDX_W bits.
- R3: With inversion off, addend select `a` adds `a * 2^(IDX_W-ADD_W)` to the index. The low IDX_W-ADD_W bits pass through unchanged. With the defaults (10 index bits, 2-bit select), the select codes 0/1/2/3 add 0/256/512/768.
- R4: With inversion on and a non-zero addend select, the index is inverted first and the addend is added to that result.
- R5: The addition wraps modulo 2^IDX_W and the carry out of the MSB is discarded. For example, 0x3FF with select 3 gives 0x2FF.
- R6: A write (`cfg_we`=1 at a rising edge) loads `{cfg_inv, cfg_add}` into the current configuration of core `cfg_core`. In the same edge it moves that core's old current configuration into its previous configuration. Both take effect for requests from the following cycle.
- R7: A write to one core leaves the current and previous configurations of every other core unchanged.
- R8: While `cfg_we`=0, no configuration changes, whatever values are on `cfg_core`, `cfg_inv` and `cfg_add`.
- R9: `prev_index` applies the same transform as `cur_index`, but uses the requesting core's previous configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_core | input | CORE_W | Core whose configuration is written |
| cfg_inv | input | 1 | New inversion enable |
| cfg_add | input | ADD_W | New addend select for the upper index bits |
| req_core | input | CORE_W | Core issuing the lookup |
| req_index | input | IDX_W | Raw set index from the address |
| cur_index | output | IDX_W | Index mapped with the current configuration |
| prev_index | output | IDX_W | Index mapped with the previous configuration |

## Verification
Directed cases put each core in a different transform: inversion alone, each addend alone, and both together. Applying the all-zeros and all-ones indices separates inversion from addition. The all-ones index with the largest addend shows whether the carry out of the MSB is dropped or leaks into the low bits. Back-to-back writes to one core separate the current register from the previous one. A write to a neighbour core, and a cycle with write data driven but the strobe low, show whether state leaks between cores or is written without the strobe. A long random mix of writes and lookups from a fixed seed then covers every core, configuration and index region against a bench model.

// File: rtl/cim_pkg.sv
package cim_pkg;

  localparam int unsigned CIM_IDX_W_DEF   = 10;
  localparam int unsigned CIM_CORES_DEF   = 4;
  localparam int unsigned CIM_ADD_W_DEF   = 2;

  // Candidate transform selector: bit0 = inversion, bit1 = non-zero addend
  typedef enum logic [1:0] {
    VAR_PLAIN = 2'b00,
    VAR_INV   = 2'b01,
    VAR_ADD   = 2'b10,
    VAR_BOTH  = 2'b11
  } cim_variant_e;

  function automatic cim_variant_e cim_pick(input logic inv, input logic add_nz);
    return cim_variant_e'({add_nz, inv});
  endfunction

endpackage

// File: rtl/cim_cfg_bank.sv
module cim_cfg_bank #(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned CFG_W   = 3,
  parameter int unsigned CORE_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [CORE_W-1:0]          wr_core,
  input  logic [CFG_W-1:0]           wr_cfg,
  output logic [N_CORES*CFG_W-1:0]   cur_flat,
  output logic [N_CORES*CFG_W-1:0]   prev_flat
);

  for (genvar c = 0; c < N_CORES; c++) begin : g_core
    logic [CFG_W-1:0] cur_q;
    logic [CFG_W-1:0] prev_q;
    logic             hit;

    assign hit = we && (wr_core == CORE_W'(c));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur_q  <= '0;
        prev_q <= '0;
      end else if (hit) begin
        cur_q  <= wr_cfg;
        prev_q <= cur_q;
      end
    end

    assign cur_flat[c*CFG_W +: CFG_W]  = cur_q;
    assign prev_flat[c*CFG_W +: CFG_W] = prev_q;
  end

endmodule

// File: rtl/cim_core_sel.sv
module cim_core_sel #(
  parameter int unsigned N_CORES = 4,
  parameter int unsigned CFG_W   = 3,
  parameter int unsigned CORE_W  = 2
) (
  input  logic [N_CORES*CFG_W-1:0] flat,
  input  logic [CORE_W-1:0]        core,
  output logic [CFG_W-1:0]         cfg
);

  always_comb begin
    cfg = '0;
    for (int c = 0; c < N_CORES; c++) begin
      if (core == CORE_W'(c)) cfg = flat[c*CFG_W +: CFG_W];
    end
  end

endmodule

// File: rtl/cim_xform.sv
module cim_xform
  import cim_pkg::*;
#(
  parameter int unsigned IDX_W = 10,
  parameter int unsigned ADD_W = 2
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             inv,
  input  logic [ADD_W-1:0] add_sel,
  output logic [IDX_W-1:0] mapped
);

  localparam int unsigned LOW_W = IDX_W - ADD_W;

  logic [IDX_W-1:0] cand_plain;
  logic [IDX_W-1:0] cand_inv;
  logic [IDX_W-1:0] cand_add;
  logic [IDX_W-1:0] cand_both;
  cim_variant_e     variant;

  assign cand_plain = idx;
  assign cand_inv   = ~idx;

  if (ADD_W == 1) begin : g_flip
    // A single select bit adds half the set count: a plain MSB flip
    assign cand_add  = {cand_plain[IDX_W-1] ^ add_sel[0], cand_plain[LOW_W-1:0]};
    assign cand_both = {cand_inv[IDX_W-1]   ^ add_sel[0], cand_inv[LOW_W-1:0]};
  end else begin : g_adder
    // Short adder confined to the upper bits; carry out is dropped
    function automatic logic [ADD_W-1:0] top_sum(input logic [ADD_W-1:0] t,
                                                 input logic [ADD_W-1:0] a);
      return t + a;
    endfunction
    assign cand_add  = {top_sum(cand_plain[IDX_W-1:LOW_W], add_sel), cand_plain[LOW_W-1:0]};
    assign cand_both = {top_sum(cand_inv[IDX_W-1:LOW_W], add_sel),   cand_inv[LOW_W-1:0]};
  end

  assign variant = cim_pick(inv, |add_sel);

  always_comb begin
    unique case (variant)
      VAR_PLAIN: mapped = cand_plain;
      VAR_INV:   mapped = cand_inv;
      VAR_ADD:   mapped = cand_add;
      VAR_BOTH:  mapped = cand_both;
      default:   mapped = cand_plain;
    endcase
  end

endmodule

// File: rtl/cache_index_mapper.sv
module cache_index_mapper
  import cim_pkg::*;
#(
  parameter int unsigned IDX_W   = CIM_IDX_W_DEF,
  parameter int unsigned N_CORES = CIM_CORES_DEF,
  parameter int unsigned ADD_W   = CIM_ADD_W_DEF,
  localparam int unsigned CORE_W = (N_CORES > 1) ? $clog2(N_CORES) : 1,
  localparam int unsigned CFG_W  = 1 + ADD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CORE_W-1:0] cfg_core,
  input  logic              cfg_inv,
  input  logic [ADD_W-1:0]  cfg_add,
  input  logic [CORE_W-1:0] req_core,
  input  logic [IDX_W-1:0]  req_index,
  output logic [IDX_W-1:0]  cur_index,
  output logic [IDX_W-1:0]  prev_index
);

  // Named internal events for the checker
  logic                     cfg_commit;
  logic [CFG_W-1:0]         cfg_word;
  logic [N_CORES*CFG_W-1:0] cur_cfg_flat;
  logic [N_CORES*CFG_W-1:0] prev_cfg_flat;
  logic [CFG_W-1:0]         sel_cur_cfg;
  logic [CFG_W-1:0]         sel_prev_cfg;

  assign cfg_commit = cfg_we;
  assign cfg_word   = {cfg_inv, cfg_add};

  cim_cfg_bank #(.N_CORES(N_CORES), .CFG_W(CFG_W), .CORE_W(CORE_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .we        (cfg_commit),
    .wr_core   (cfg_core),
    .wr_cfg    (cfg_word),
    .cur_flat  (cur_cfg_flat),
    .prev_flat (prev_cfg_flat)
  );

  cim_core_sel #(.N_CORES(N_CORES), .CFG_W(CFG_W), .CORE_W(CORE_W)) u_sel_cur (
    .flat (cur_cfg_flat),
    .core (req_core),
    .cfg  (sel_cur_cfg)
  );

  cim_core_sel #(.N_CORES(N_CORES), .CFG_W(CFG_W), .CORE_W(CORE_W)) u_sel_prev (
    .flat (prev_cfg_flat),
    .core (req_core),
    .cfg  (sel_prev_cfg)
  );

  cim_xform #(.IDX_W(IDX_W), .ADD_W(ADD_W)) u_xf_cur (
    .idx     (req_index),
    .inv     (sel_cur_cfg[CFG_W-1]),
    .add_sel (sel_cur_cfg[ADD_W-1:0]),
    .mapped  (cur_index)
  );

  cim_xform #(.IDX_W(IDX_W), .ADD_W(ADD_W)) u_xf_prev (
    .idx     (req_index),
    .inv     (sel_prev_cfg[CFG_W-1]),
    .add_sel (sel_prev_cfg[ADD_W-1:0]),
    .mapped  (prev_index)
  );

endmodule

// File: rtl/cim_checker.sv
module cim_checker #(
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned N_CORES = 4,
  parameter int unsigned ADD_W   = 2,
  parameter int unsigned CORE_W  = 2,
  parameter int unsigned CFG_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_commit,
  input logic [CORE_W-1:0]        cfg_core,
  input logic [CFG_W-1:0]         cfg_word,
  input logic [IDX_W-1:0]         req_index,
  input logic [IDX_W-1:0]         cur_index,
  input logic [IDX_W-1:0]         prev_index,
  input logic [CFG_W-1:0]         sel_cur_cfg,
  input logic [CFG_W-1:0]         sel_prev_cfg,
  input logic [N_CORES*CFG_W-1:0] cur_cfg_flat,
  input logic [N_CORES*CFG_W-1:0] prev_cfg_flat
);

  localparam int unsigned LOW_W = IDX_W - ADD_W;

  // R3: without inversion the low bits pass through
  p_low_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_cur_cfg[CFG_W-1] |-> cur_index[LOW_W-1:0] == req_index[LOW_W-1:0]);

  // R2 / R4: with inversion the low bits are complemented
  p_low_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cur_cfg[CFG_W-1] |-> cur_index[LOW_W-1:0] == ~req_index[LOW_W-1:0]);

  // R6: written word becomes the current configuration
  p_write_cur_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_commit |=> cur_cfg_flat[int'($past(cfg_core))*CFG_W +: CFG_W] == $past(cfg_word));

  // R6: old current moves into previous
  p_write_prev_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_commit |=> prev_cfg_flat[int'($past(cfg_core))*CFG_W +: CFG_W] ==
                   $past(cur_cfg_flat[int'(cfg_core)*CFG_W +: CFG_W]));

  // R8: no strobe, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_commit |=> $stable(cur_cfg_flat) && $stable(prev_cfg_flat));

  // R9: identical configurations give identical indices
  p_prev_same_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_cur_cfg == sel_prev_cfg) |-> cur_index == prev_index);

endmodule

bind cache_index_mapper cim_checker #(
  .IDX_W(IDX_W), .N_CORES(N_CORES), .ADD_W(ADD_W), .CORE_W(CORE_W), .CFG_W(CFG_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_commit    (cfg_commit),
  .cfg_core      (cfg_core),
  .cfg_word      (cfg_word),
  .req_index     (req_index),
  .cur_index     (cur_index),
  .prev_index    (prev_index),
  .sel_cur_cfg   (sel_cur_cfg),
  .sel_prev_cfg  (sel_prev_cfg),
  .cur_cfg_flat  (cur_cfg_flat),
  .prev_cfg_flat (prev_cfg_flat)
);

// File: tb/sim_cache_index_mapper.sv
module sim_cache_index_mapper;

  localparam int IDX_W  = 10;
  localparam int NC     = 4;
  localparam int ADD_W  = 2;
  localparam int CORE_W = 2;
  localparam int LOW_W  = IDX_W - ADD_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [CORE_W-1:0] cfg_core = '0;
  logic              cfg_inv = 1'b0;
  logic [ADD_W-1:0]  cfg_add = '0;
  logic [CORE_W-1:0] req_core = '0;
  logic [IDX_W-1:0]  req_index = '0;
  logic [IDX_W-1:0]  cur_index;
  logic [IDX_W-1:0]  prev_index;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Bench model of configuration state
  bit             m_inv  [NC];
  bit [ADD_W-1:0] m_add  [NC];
  bit             p_inv  [NC];
  bit [ADD_W-1:0] p_add  [NC];

  always #2 clk = ~clk;

  cache_index_mapper u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_core(cfg_core),
    .cfg_inv(cfg_inv), .cfg_add(cfg_add), .req_core(req_core),
    .req_index(req_index), .cur_index(cur_index), .prev_index(prev_index)
  );

  // Expected mapping: complement, then add select * 2^LOW_W over the full width
  function automatic logic [IDX_W-1:0] exp_map(input logic [IDX_W-1:0] idx,
                                               input bit inv, input bit [ADD_W-1:0] a);
    int unsigned v;
    v = inv ? ((1 << IDX_W) - 1 - int'(idx)) : int'(idx);
    v = (v + int'(a) * (1 << LOW_W)) % (1 << IDX_W);
    return v[IDX_W-1:0];
  endfunction

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic wr(input int core, input bit inv, input bit [ADD_W-1:0] a);
    @(negedge clk);
    cfg_we = 1'b1; cfg_core = CORE_W'(core); cfg_inv = inv; cfg_add = a;
    @(posedge clk);
    #1 cfg_we = 1'b0;
    p_inv[core] = m_inv[core]; p_add[core] = m_add[core];
    m_inv[core] = inv;         m_add[core] = a;
  endtask

  task automatic chk(input int core, input logic [IDX_W-1:0] idx, input string req);
    logic [IDX_W-1:0] ec, ep;
    @(negedge clk);
    req_core = CORE_W'(core); req_index = idx;
    #1;
    ec = exp_map(idx, m_inv[core], m_add[core]);
    ep = exp_map(idx, p_inv[core], p_add[core]);
    n_vec++;
    if (cur_index !== ec) begin
      n_bad++;
      $display("FAIL %s cur core=%0d idx=%h actual=%h expected=%h", req, core, idx, cur_index, ec);
    end
    n_vec++;
    if (prev_index !== ep) begin
      n_bad++;
      $display("FAIL %s prev core=%0d idx=%h actual=%h expected=%h", req, core, idx, prev_index, ep);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < NC; c++) begin
      m_inv[c] = 0; m_add[c] = 0; p_inv[c] = 0; p_add[c] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: identity after reset on every core
    for (int c = 0; c < NC; c++) begin
      chk(c, 10'h000, "R1");
      chk(c, 10'h3FF, "R1");
      chk(c, 10'h15A, "R1");
    end

    // R2: inversion only on core 0
    wr(0, 1'b1, 2'd0);
    chk(0, 10'h000, "R2");
    chk(0, 10'h3FF, "R2");
    chk(0, 10'h2C3, "R2");
    // R7: the other cores still map the identity
    chk(1, 10'h2C3, "R7");
    chk(3, 10'h001, "R7");

    // R3: each addend on core 1, low bits preserved
    wr(1, 1'b0, 2'd1);
    chk(1, 10'h0AB, "R3");
    wr(1, 1'b0, 2'd2);
    chk(1, 10'h0AB, "R3");
    chk(1, 10'h2AB, "R3");
    wr(1, 1'b0, 2'd3);
    chk(1, 10'h000, "R3");
    // R5: wrap drops carry: 0x3FF + 768 -> 0x2FF
    chk(1, 10'h3FF, "R5");
    chk(1, 10'h1FF, "R5");
    // R9 / R6: previous mapping is the select-2 transform
    chk(1, 10'h155, "R9");

    // R4: inversion then addition on core 2: 0x000 -> 0x3FF + 256 -> 0x0FF
    wr(2, 1'b1, 2'd1);
    chk(2, 10'h000, "R4");
    chk(2, 10'h2F0, "R4");

    // R6: back-to-back writes on core 3
    wr(3, 1'b0, 2'd2);
    wr(3, 1'b1, 2'd3);
    chk(3, 10'h123, "R6");
    chk(0, 10'h123, "R7");

    // R8: write data without strobe has no effect
    @(negedge clk);
    cfg_core = 2'd0; cfg_inv = 1'b0; cfg_add = 2'd3;
    repeat (3) @(posedge clk);
    chk(0, 10'h0F0, "R8");
    chk(3, 10'h0F0, "R8");

    // Random mix of writes and lookups
    for (int i = 0; i < 3000; i++) begin
      int unsigned r;
      r = $urandom;
      if (r[1:0] == 2'b00)
        wr(int'(r[3:2]), r[4], r[6:5]);
      else
        chk(int'(r[8:7]), r[18:9], "R6");
    end

    done = 1'b1;
    report();
    $finish;
  end

endmodule